// File: doc/BRIEF.md
# Fractional PLL Output Rate Calculator

This block works out the output frequency of a fractional-N synthesizer from the reference rate and the programmed loop settings: an integer multiplier M, a pre-divider N and a fractional word F scaled by a full-scale value Fmax. The result is ref × (M + F/Fmax) / N. All intermediate values are held in 64-bit arithmetic. Two rounding steps are applied. The fractional contribution ref × F / Fmax is rounded up on its own before it is added to ref × M. The sum is then rounded up again when it is divided by N.

A caller presents the operands with a one-cycle start strobe. The block then runs a shift-add multiplier and a restoring divider, one bit per cycle, and raises a done pulse when the rate is ready. Fmax comes from a configuration input. When that input is zero, Fmax is taken as two to the power of a configured fraction width. A zero pre-divider does not fault: it finishes immediately with a zero rate.

Top module: `frac_pll_rate_calc`

## Requirements
- R1: The integer term is ref_rate_i × mult_i, formed in a 64-bit accumulator without loss.
- R2: When frac_en_i is 1 and frac_i is non-zero, ceil(ref_rate_i × frac_i / Fmax) is added to the integer term.
- R3: The final rate is ceil(sum / prediv_i), computed as (sum + prediv_i − 1) / prediv_i.
- R4: Fmax is frac_max_i when that input is non-zero. Otherwise Fmax is 2^frac_w_i, with frac_w_i clamped to at most F_W.
- R5: prediv_i = 0 gives rate_o = 0 with done_o high in the cycle right after the start edge, and no arithmetic is run.
- R6: When frac_en_i is 0, frac_i has no effect on the result. A frac_i of 0 adds nothing and skips the fractional phase.
- R7: With a non-zero pre-divider, done_o is high exactly M_W+64 cycles after the accepting edge when no fraction is used, and M_W+F_W+128 cycles after it when a fraction is used.
- R8: done_o is high for a single cycle. rate_o changes only in a done cycle and holds its value until the next completion.
- R9: busy_o is high from the cycle after an accepted start through the done cycle. A start_i while busy_o is high is ignored, and so are operand changes while busy_o is high.
- R10: While reset is asserted and after it is released, busy_o, done_o and rate_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe; sampled only when idle |
| ref_rate_i | input | RATE_W | Reference input rate |
| mult_i | input | M_W | Integer multiplier M |
| prediv_i | input | N_W | Pre-divider N |
| frac_i | input | F_W | Fractional word F |
| frac_en_i | input | 1 | Fractional field present |
| frac_max_i | input | F_W+1 | Fraction full scale; 0 selects 2^frac_w_i |
| frac_w_i | input | FWW | Fraction field width used when frac_max_i is 0 |
| busy_o | output | 1 | Calculation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| rate_o | output | 64 | Computed output rate |

## Verification
The assertions check the following on every cycle: done_o is a single-cycle pulse, and busy_o covers it. A running calculation keeps busy_o high until done. The divisor is never zero while a division runs. A zero pre-divider finishes with a zero rate one cycle after acceptance. rate_o moves only in a done cycle. The exact completion cycle and the rounded values need the bench's scenarios, since they are only visible against an independent arithmetic model. These values are the ceiling steps of both divisions, the Fmax fallback with width clamping, and the fraction being ignored when disabled or zero.

// File: rtl/pll_rate_pkg.sv
package pll_rate_pkg;
  localparam int ACC_W = 64;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_MUL_INT,
    ST_MUL_FRAC,
    ST_DIV_FRAC,
    ST_DIV_N,
    ST_FIN
  } pll_state_e;
endpackage

// File: rtl/pll_fmax_sel.sv
module pll_fmax_sel #(
  parameter int F_W = 17,
  parameter int FWW = $clog2(F_W + 1)
) (
  input  logic [F_W:0]   cfg_i,
  input  logic [FWW-1:0] width_i,
  output logic [F_W:0]   fmax_o
);
  logic [FWW-1:0] w_cl;

  always_comb begin
    w_cl   = (width_i > FWW'(F_W)) ? FWW'(F_W) : width_i;
    fmax_o = (cfg_i != '0) ? cfg_i : ((F_W+1)'(1) << w_cl);
  end
endmodule

// File: rtl/pll_mul_step.sv
module pll_mul_step #(
  parameter int W = 64,
  parameter int B = 17
) (
  input  logic [W-1:0] acc_i,
  input  logic [W-1:0] ma_i,
  input  logic [B-1:0] mb_i,
  output logic [W-1:0] acc_o,
  output logic [W-1:0] ma_o,
  output logic [B-1:0] mb_o
);
  always_comb begin
    acc_o = mb_i[0] ? acc_i + ma_i : acc_i;
    ma_o  = ma_i << 1;
    mb_o  = mb_i >> 1;
  end
endmodule

// File: rtl/pll_div_step.sv
module pll_div_step #(
  parameter int W = 64
) (
  input  logic [W-1:0] rem_i,
  input  logic [W-1:0] quo_i,
  input  logic [W-1:0] den_i,
  output logic [W-1:0] rem_o,
  output logic [W-1:0] quo_o
);
  logic [W:0] rem_sh;
  logic [W:0] diff;
  logic       ge;

  always_comb begin
    rem_sh = {rem_i, quo_i[W-1]};
    diff   = rem_sh - {1'b0, den_i};
    ge     = rem_sh >= {1'b0, den_i};
    rem_o  = ge ? diff[W-1:0] : rem_sh[W-1:0];
    quo_o  = {quo_i[W-2:0], ge};
  end
endmodule

// File: rtl/frac_pll_rate_calc.sv
module frac_pll_rate_calc #(
  parameter int RATE_W = 32,
  parameter int M_W    = 9,
  parameter int N_W    = 6,
  parameter int F_W    = 17,
  parameter int FWW    = $clog2(F_W + 1)
) (
  input  logic                                 clk_i,
  input  logic                                 rst_ni,
  input  logic                                 start_i,
  input  logic [RATE_W-1:0]                    ref_rate_i,
  input  logic [M_W-1:0]                       mult_i,
  input  logic [N_W-1:0]                       prediv_i,
  input  logic [F_W-1:0]                       frac_i,
  input  logic                                 frac_en_i,
  input  logic [F_W:0]                         frac_max_i,
  input  logic [FWW-1:0]                       frac_w_i,
  output logic                                 busy_o,
  output logic                                 done_o,
  output logic [pll_rate_pkg::ACC_W-1:0]       rate_o
);
  import pll_rate_pkg::*;

  localparam int MB_W  = (M_W > F_W) ? M_W : F_W;
  localparam int CNT_W = $clog2(ACC_W + 1);

  pll_state_e       state_q;
  logic [CNT_W-1:0] cnt_q;
  logic [ACC_W-1:0] acc_q, ma_q, rem_q, quo_q, den_q, sum_q, rate_q;
  logic [ACC_W-1:0] ref_q, n_q, fmax_q;
  logic [MB_W-1:0]  mb_q, frac_q;
  logic             use_frac_q;

  logic [ACC_W-1:0] acc_n, ma_n, rem_n, quo_n;
  logic [MB_W-1:0]  mb_n;
  logic [F_W:0]     fmax_eff;
  logic             last;

  pll_fmax_sel #(.F_W(F_W), .FWW(FWW)) u_fmax (
    .cfg_i(frac_max_i), .width_i(frac_w_i), .fmax_o(fmax_eff)
  );

  pll_mul_step #(.W(ACC_W), .B(MB_W)) u_mul (
    .acc_i(acc_q), .ma_i(ma_q), .mb_i(mb_q),
    .acc_o(acc_n), .ma_o(ma_n), .mb_o(mb_n)
  );

  pll_div_step #(.W(ACC_W)) u_div (
    .rem_i(rem_q), .quo_i(quo_q), .den_i(den_q),
    .rem_o(rem_n), .quo_o(quo_n)
  );

  assign last = (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      cnt_q      <= '0;
      acc_q      <= '0;
      ma_q       <= '0;
      mb_q       <= '0;
      rem_q      <= '0;
      quo_q      <= '0;
      den_q      <= '0;
      sum_q      <= '0;
      rate_q     <= '0;
      ref_q      <= '0;
      n_q        <= '0;
      fmax_q     <= '0;
      frac_q     <= '0;
      use_frac_q <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          ref_q      <= ACC_W'(ref_rate_i);
          n_q        <= ACC_W'(prediv_i);
          frac_q     <= MB_W'(frac_i);
          fmax_q     <= ACC_W'(fmax_eff);
          use_frac_q <= frac_en_i && (frac_i != '0);
          ma_q       <= ACC_W'(ref_rate_i);
          mb_q       <= MB_W'(mult_i);
          acc_q      <= '0;
          cnt_q      <= CNT_W'(M_W - 1);
          if (prediv_i == '0) begin
            rate_q  <= '0;
            state_q <= ST_FIN;
          end else begin
            state_q <= ST_MUL_INT;
          end
        end
        ST_MUL_INT: begin
          acc_q <= acc_n;
          ma_q  <= ma_n;
          mb_q  <= mb_n;
          cnt_q <= cnt_q - 1'b1;
          if (last) begin
            sum_q <= acc_n;
            if (use_frac_q) begin
              ma_q    <= ref_q;
              mb_q    <= frac_q;
              acc_q   <= '0;
              cnt_q   <= CNT_W'(F_W - 1);
              state_q <= ST_MUL_FRAC;
            end else begin
              rem_q   <= '0;
              quo_q   <= acc_n + n_q - ACC_W'(1);
              den_q   <= n_q;
              cnt_q   <= CNT_W'(ACC_W - 1);
              state_q <= ST_DIV_N;
            end
          end
        end
        ST_MUL_FRAC: begin
          acc_q <= acc_n;
          ma_q  <= ma_n;
          mb_q  <= mb_n;
          cnt_q <= cnt_q - 1'b1;
          if (last) begin
            rem_q   <= '0;
            quo_q   <= acc_n + fmax_q - ACC_W'(1);
            den_q   <= fmax_q;
            cnt_q   <= CNT_W'(ACC_W - 1);
            state_q <= ST_DIV_FRAC;
          end
        end
        ST_DIV_FRAC: begin
          rem_q <= rem_n;
          quo_q <= quo_n;
          cnt_q <= cnt_q - 1'b1;
          if (last) begin
            sum_q   <= sum_q + quo_n;
            rem_q   <= '0;
            quo_q   <= sum_q + quo_n + n_q - ACC_W'(1);
            den_q   <= n_q;
            cnt_q   <= CNT_W'(ACC_W - 1);
            state_q <= ST_DIV_N;
          end
        end
        ST_DIV_N: begin
          rem_q <= rem_n;
          quo_q <= quo_n;
          cnt_q <= cnt_q - 1'b1;
          if (last) begin
            rate_q  <= quo_n;
            state_q <= ST_FIN;
          end
        end
        ST_FIN:  state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o = (state_q != ST_IDLE);
  assign done_o = (state_q == ST_FIN);
  assign rate_o = rate_q;

  // R8: completion is a single-cycle pulse
  p_done_one_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R8: result register moves only into a done cycle
  p_rate_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(rate_o) |-> done_o);

  // R9: a running calculation stays busy until done
  p_hold_busy_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !done_o) |=> busy_o);

  // R9: done is always inside the busy window
  p_done_busy_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> busy_o);

  // R9: captured operands do not move while busy
  p_opnd_stable_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !done_o) |=> $stable(n_q) && $stable(ref_q));

  // R5: zero pre-divider finishes next cycle with zero rate
  p_nzero_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && start_i && prediv_i == '0) |=> (done_o && rate_o == '0));

  // R3: a running division never has a zero divisor
  p_divisor_nz_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_DIV_N || state_q == ST_DIV_FRAC) |-> (den_q != '0));
endmodule

// File: tb/frac_pll_rate_calc_tb_top.sv
`timescale 1ns/1ps
module frac_pll_rate_calc_tb_top;
  localparam int RATE_W = 32;
  localparam int M_W    = 9;
  localparam int N_W    = 6;
  localparam int F_W    = 17;
  localparam int FWW    = $clog2(F_W + 1);

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              start = 1'b0;
  logic [RATE_W-1:0] ref_rate = '0;
  logic [M_W-1:0]    mult = '0;
  logic [N_W-1:0]    prediv = '0;
  logic [F_W-1:0]    frac = '0;
  logic              frac_en = 1'b0;
  logic [F_W:0]      frac_max = '0;
  logic [FWW-1:0]    frac_w = '0;
  logic              busy, done;
  logic [63:0]       rate;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #10 clk = ~clk;

  frac_pll_rate_calc #(.RATE_W(RATE_W), .M_W(M_W), .N_W(N_W), .F_W(F_W)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .ref_rate_i(ref_rate),
    .mult_i(mult), .prediv_i(prediv), .frac_i(frac), .frac_en_i(frac_en),
    .frac_max_i(frac_max), .frac_w_i(frac_w),
    .busy_o(busy), .done_o(done), .rate_o(rate)
  );

  // behavioural model
  function automatic longint unsigned model_rate(longint unsigned r, longint unsigned m,
      longint unsigned n, longint unsigned f, bit en, longint unsigned fm, int w);
    longint unsigned s, fmx;
    int wc;
    wc  = (w > F_W) ? F_W : w;
    fmx = (fm != 0) ? fm : (64'd1 << wc);
    s   = r * m;
    if (en && f != 0) s += (r * f + fmx - 1) / fmx;
    if (n == 0) return 0;
    return (s + n - 1) / n;
  endfunction

  bit              m_busy = 1'b0;
  int              m_cnt = 0;
  longint unsigned m_exp = 0;
  longint unsigned m_last = 0;
  string           m_tag = "R1";
  string           cur_tag = "R1";

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy <= 1'b0;
    end else if (m_busy) begin
      if (m_cnt == 0) begin
        m_busy <= 1'b0;
        m_last <= m_exp;
      end else m_cnt <= m_cnt - 1;
    end else if (start) begin
      m_busy <= 1'b1;
      m_cnt  <= (prediv == 0) ? 0 :
                M_W + 64 + ((frac_en && frac != 0) ? F_W + 64 : 0);
      m_exp  <= model_rate(ref_rate, mult, prediv, frac, frac_en, frac_max, int'(frac_w));
      m_tag  <= cur_tag;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      bit exp_done;
      exp_done = m_busy && (m_cnt == 0);
      checks++;
      if (busy !== m_busy) begin
        errors++;
        $display("FAIL R9 busy_o act=%0b exp=%0b cycle=%0d", busy, m_busy, cyc);
      end
      checks++;
      if (done !== exp_done) begin
        errors++;
        $display("FAIL R7 done_o act=%0b exp=%0b cycle=%0d", done, exp_done, cyc);
      end
      checks++;
      if (exp_done) begin
        if (rate !== m_exp) begin
          errors++;
          $display("FAIL %s rate_o act=%0d exp=%0d", m_tag, rate, m_exp);
        end
      end else if (rate !== m_last) begin
        errors++;
        $display("FAIL R8 rate_o held act=%0d exp=%0d", rate, m_last);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic run_op(input longint unsigned r, input int m, input int n, input int f,
                        input bit en, input int fm, input int w, input string tag);
    @(negedge clk);
    cur_tag  = tag;
    ref_rate = RATE_W'(r);
    mult     = M_W'(m);
    prediv   = N_W'(n);
    frac     = F_W'(f);
    frac_en  = en;
    frac_max = (F_W+1)'(fm);
    frac_w   = FWW'(w);
    start    = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (m_busy) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset values
    checks++;
    if (busy !== 1'b0 || done !== 1'b0 || rate !== 64'd0) begin
      errors++;
      $display("FAIL R10 reset act=%0b%0b%0d exp=000", busy, done, rate);
    end
    rst_n = 1'b1;
    @(negedge clk);

    run_op(24_000_000, 100, 1, 0, 1'b0, 0, 0, "R1");          // R1 integer only
    run_op(32'hFFFF_FFFF, 511, 1, 0, 1'b0, 0, 0, "R1");       // R1 wide product
    run_op(24_000_000, 41, 3, 0, 1'b0, 0, 0, "R3");           // R3 ceiling by N
    run_op(1000, 7, 7, 0, 1'b0, 0, 0, "R3");                  // R3 exact division
    run_op(24_000_000, 50, 1, 12345, 1'b1, 100000, 0, "R2");  // R2 explicit Fmax
    run_op(3, 1, 2, 1, 1'b1, 7, 0, "R2");                     // R2 fraction ceiling
    run_op(24_000_000, 40, 2, 5000, 1'b1, 0, 14, "R4");       // R4 2^14
    run_op(999_999, 33, 5, 131071, 1'b1, 0, 31, "R4");        // R4 width clamped to F_W
    run_op(24_000_000, 50, 1, 12345, 1'b0, 100000, 0, "R6");  // R6 fraction disabled
    run_op(24_000_000, 50, 1, 0, 1'b1, 100000, 0, "R6");      // R6 zero fraction
    run_op(24_000_000, 50, 0, 777, 1'b1, 0, 10, "R5");        // R5 zero pre-divider
    run_op(5, 0, 4, 0, 1'b0, 0, 0, "R5");                     // zero multiplier
    run_op(5, 3, 0, 0, 1'b0, 0, 0, "R5");

    // R9: start and operand changes during busy are ignored
    @(negedge clk);
    cur_tag  = "R9";
    ref_rate = 32'd10_000_000; mult = 9'd20; prediv = 6'd3; frac = '0; frac_en = 1'b0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (5) @(negedge clk);
    prediv = '0; mult = 9'd1; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    start = 1'b1;
    repeat (2) @(negedge clk);
    start = 1'b0;
    while (m_busy) @(negedge clk);

    // R7/R8 random patterns
    for (int i = 0; i < 40; i++) begin
      run_op({$urandom}, int'($urandom_range(0, 511)), int'($urandom_range(0, 63)),
             (i % 4 == 0) ? 0 : int'($urandom_range(0, 131071)),
             1'($urandom_range(0, 1)),
             (i % 3 == 0) ? 0 : int'($urandom_range(1, 131072)),
             int'($urandom_range(0, 20)), "R7");
    end

    repeat (3) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule